// File: doc/BRIEF.md
# Debug Boot Reset Controller

This block keeps a sticky debug-boot indication that a probe sets or clears through two test-access-port instruction strobes. The indication survives a processor reset. While the processor is held in reset, three debug control bits take their reset values from it: a break request, a probe-trap vector select and a probe-enable. A power-on reset, which also stands for a TAP reset, clears the indication and all three bits.

When the processor leaves reset with the break request set, the block raises a one-cycle debug interrupt request. The request does not repeat until the break-request bit has been cleared by the core's acknowledge and then set again. The probe-trap bit steers the fetch vector from the normal reset address to the debug vector in probe memory. When both the probe-trap and probe-enable bits are set, the first fetch after reset is served by the probe. The block then marks a processor access as pending and stalls fetch until the probe signals that an instruction word is valid. Later probe-memory fetches that the core flags are handled in the same way.

Top module: `dbgboot_ctrl`

## Requirements
- R1: While `por_n` is low, `boot_ind_o`, `brk_o`, `trap_o`, `pen_o`, `dbg_irq_o`, `stall_o` and `acc_pend_o` are 0, and `fetch_vec_o` is 0xBFC00000. The clear takes effect without waiting for a clock edge.
- R2: A one-cycle pulse on `tap_dbgboot_i` sets `boot_ind_o` at the next edge. `boot_ind_o` then holds its value through any number of cycles with `cpu_rst_n` low.
- R3: A pulse on `tap_normboot_i` clears `boot_ind_o` at the next edge. If both strobes are high in the same cycle, the clear wins.
- R4: At every clock edge with `cpu_rst_n` low, `brk_o`, `trap_o` and `pen_o` each load the current value of `boot_ind_o`.
- R5: `fetch_vec_o` is 0xFF200200 while `trap_o` is 1 and 0xBFC00000 while it is 0.
- R6: In the first cycle with `cpu_rst_n` high after a reset, `dbg_irq_o` equals `brk_o`, combinationally. It is high for exactly one cycle.
- R7: While `cpu_rst_n` is high, `brk_ack_i` clears `brk_o` at the next edge and `brk_set_i` sets it. `brk_set_i` wins when both are high together. `dbg_irq_o` rises again only after `brk_o` has been 0 and is then set again.
- R8: In the first cycle out of reset with `trap_o` and `pen_o` both 1, `stall_o` is high at once and `acc_pend_o` is high from the next edge. `acc_pend_o` stays high until the probe answers.
- R9: In a cycle with `acc_pend_o` and `probe_ivalid_i` both high, `stall_o` is 0, and `acc_pend_o` is 0 after the edge. `probe_ivalid_i` has no effect while no access is pending.
- R10: A `pfetch_i` pulse with `pen_o` high and nothing pending raises `stall_o` at once and `acc_pend_o` at the next edge. With `pen_o` low, `pfetch_i` has no effect on `stall_o` or `acc_pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / TAP reset, asynchronous, active low |
| cpu_rst_n | input | 1 | Processor reset, sampled on the clock, active low |
| tap_dbgboot_i | input | 1 | Decoded debug-boot instruction strobe |
| tap_normboot_i | input | 1 | Decoded normal-boot instruction strobe |
| brk_set_i | input | 1 | Sets the break-request bit |
| brk_ack_i | input | 1 | Core acknowledge of the debug interrupt; clears break request |
| pfetch_i | input | 1 | Core issues a fetch to probe memory |
| probe_ivalid_i | input | 1 | Probe has supplied the instruction word |
| boot_ind_o | output | 1 | Sticky debug-boot indication |
| brk_o | output | 1 | Break-request control bit |
| trap_o | output | 1 | Probe-trap vector select bit |
| pen_o | output | 1 | Probe-enable control bit |
| dbg_irq_o | output | 1 | One-cycle debug interrupt request |
| fetch_vec_o | output | 32 | Fetch vector address |
| stall_o | output | 1 | Fetch stall |
| acc_pend_o | output | 1 | Processor access pending at the probe |

## Verification
The outputs `dbg_irq_o`, `stall_o` and `fetch_vec_o` follow the inputs and state of the current cycle with no added register. They are sampled two time units after the falling edge at which the stimulus is driven. The indication, the three control bits and `acc_pend_o` change at the rising edge that follows the stimulus, and are checked at the next falling edge. The exception is the control-bit load in reset: it takes one more edge to pass a freshly set indication on to the bits, so those checks wait two edges. The sweep covers both boot settings, several probe answer delays and several acknowledge delays, with the expected values computed from the boot setting alone.

// File: rtl/dbgboot_pkg.sv
package dbgboot_pkg;
  parameter int VEC_W = 32;

  localparam int CTL_BRK  = 0;
  localparam int CTL_TRAP = 1;
  localparam int CTL_PEN  = 2;
  localparam int CTL_N    = 3;

  // vector selection: probe-memory debug vector when the trap bit is set
  function automatic logic [VEC_W-1:0] pick_vec(input logic trap,
                                                 input logic [VEC_W-1:0] dbg_vec,
                                                 input logic [VEC_W-1:0] rst_vec);
    return trap ? dbg_vec : rst_vec;
  endfunction

  // a fetch is served by the probe when the vector is in probe memory
  // and probe service is enabled
  function automatic logic probe_served(input logic trap, input logic pen);
    return trap & pen;
  endfunction
endpackage

// File: rtl/dbgboot_flag.sv
module dbgboot_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // clear has priority; processor reset does not touch the flag
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dbgboot_ctl.sv
module dbgboot_ctl
  import dbgboot_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             cpu_rst_n,
  input  logic             boot_i,
  input  logic             brk_set_i,
  input  logic             brk_ack_i,
  output logic [CTL_N-1:0] ctl_o,
  output logic             irq_o
);
  logic [CTL_N-1:0] ctl_q;
  logic             issued_q;

  for (genvar i = 0; i < CTL_N; i++) begin : g_bit
    logic bit_q;
    if (i == CTL_BRK) begin : g_brk
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          bit_q <= 1'b0;
        else if (!cpu_rst_n) bit_q <= boot_i;
        else if (brk_set_i)  bit_q <= 1'b1;
        else if (brk_ack_i)  bit_q <= 1'b0;
      end
    end else begin : g_hold
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          bit_q <= 1'b0;
        else if (!cpu_rst_n) bit_q <= boot_i;
      end
    end
    assign ctl_q[i] = bit_q;
  end

  // one pulse per setting of the break-request bit
  assign irq_o = cpu_rst_n & ctl_q[CTL_BRK] & ~issued_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 issued_q <= 1'b0;
    else if (!cpu_rst_n)        issued_q <= 1'b0;
    else if (irq_o)             issued_q <= 1'b1;
    else if (!ctl_q[CTL_BRK])   issued_q <= 1'b0;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/dbgboot_fetch.sv
module dbgboot_fetch
  import dbgboot_pkg::*;
#(
  parameter logic [VEC_W-1:0] DBG_VEC = 32'hFF200200,
  parameter logic [VEC_W-1:0] RST_VEC = 32'hBFC00000
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cpu_rst_n,
  input  logic             trap_i,
  input  logic             pen_i,
  input  logic             pfetch_i,
  input  logic             pvalid_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             stall_o,
  output logic             pend_o,
  output logic             pend_set_o,
  output logic             pend_clr_o
);
  logic started_q;
  logic pend_q;
  logic first_fetch;

  assign first_fetch = cpu_rst_n & ~started_q;
  assign pend_set_o  = cpu_rst_n & ~pend_q &
                       ((first_fetch & probe_served(trap_i, pen_i)) | (pfetch_i & pen_i));
  assign pend_clr_o  = pend_q & pvalid_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          started_q <= 1'b0;
    else if (!cpu_rst_n) started_q <= 1'b0;
    else                 started_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          pend_q <= 1'b0;
    else if (!cpu_rst_n) pend_q <= 1'b0;
    else if (pend_set_o) pend_q <= 1'b1;
    else if (pend_clr_o) pend_q <= 1'b0;
  end

  assign vec_o   = pick_vec(trap_i, DBG_VEC, RST_VEC);
  assign stall_o = pend_set_o | (pend_q & ~pvalid_i);
  assign pend_o  = pend_q;
endmodule

// File: rtl/dbgboot_ctrl.sv
module dbgboot_ctrl
  import dbgboot_pkg::*;
#(
  parameter logic [VEC_W-1:0] DBG_VEC = 32'hFF200200,
  parameter logic [VEC_W-1:0] RST_VEC = 32'hBFC00000
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cpu_rst_n,
  input  logic             tap_dbgboot_i,
  input  logic             tap_normboot_i,
  input  logic             brk_set_i,
  input  logic             brk_ack_i,
  input  logic             pfetch_i,
  input  logic             probe_ivalid_i,
  output logic             boot_ind_o,
  output logic             brk_o,
  output logic             trap_o,
  output logic             pen_o,
  output logic             dbg_irq_o,
  output logic [VEC_W-1:0] fetch_vec_o,
  output logic             stall_o,
  output logic             acc_pend_o
);
  logic             boot_flag;
  logic [CTL_N-1:0] ctl;
  logic             pend_set;
  logic             pend_clr;

  dbgboot_flag u_flag (
    .clk    (clk),
    .por_n  (por_n),
    .set_i  (tap_dbgboot_i),
    .clr_i  (tap_normboot_i),
    .flag_o (boot_flag)
  );

  dbgboot_ctl u_ctl (
    .clk       (clk),
    .por_n     (por_n),
    .cpu_rst_n (cpu_rst_n),
    .boot_i    (boot_flag),
    .brk_set_i (brk_set_i),
    .brk_ack_i (brk_ack_i),
    .ctl_o     (ctl),
    .irq_o     (dbg_irq_o)
  );

  dbgboot_fetch #(
    .DBG_VEC (DBG_VEC),
    .RST_VEC (RST_VEC)
  ) u_fetch (
    .clk        (clk),
    .por_n      (por_n),
    .cpu_rst_n  (cpu_rst_n),
    .trap_i     (ctl[CTL_TRAP]),
    .pen_i      (ctl[CTL_PEN]),
    .pfetch_i   (pfetch_i),
    .pvalid_i   (probe_ivalid_i),
    .vec_o      (fetch_vec_o),
    .stall_o    (stall_o),
    .pend_o     (acc_pend_o),
    .pend_set_o (pend_set),
    .pend_clr_o (pend_clr)
  );

  assign boot_ind_o = boot_flag;
  assign brk_o      = ctl[CTL_BRK];
  assign trap_o     = ctl[CTL_TRAP];
  assign pen_o      = ctl[CTL_PEN];
endmodule

// File: rtl/dbgboot_chk.sv
module dbgboot_chk (
  input logic        clk,
  input logic        por_n,
  input logic        cpu_rst_n,
  input logic        tap_dbgboot_i,
  input logic        tap_normboot_i,
  input logic        brk_set_i,
  input logic        pfetch_i,
  input logic        probe_ivalid_i,
  input logic        boot_ind_o,
  input logic        brk_o,
  input logic        trap_o,
  input logic        pen_o,
  input logic        dbg_irq_o,
  input logic        stall_o,
  input logic        acc_pend_o
);
  a_r2_flag_survives: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_rst_n && !tap_dbgboot_i && !tap_normboot_i) |=> $stable(boot_ind_o));

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!por_n)
    tap_normboot_i |=> !boot_ind_o);

  a_r4_bits_load: assert property (@(posedge clk) disable iff (!por_n)
    !cpu_rst_n |=> (brk_o == $past(boot_ind_o) && trap_o == $past(boot_ind_o)
                    && pen_o == $past(boot_ind_o)));

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!por_n)
    dbg_irq_o |=> !dbg_irq_o);

  a_r6_irq_needs_brk: assert property (@(posedge clk) disable iff (!por_n)
    dbg_irq_o |-> (brk_o && cpu_rst_n));

  a_r7_no_retrigger: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_rst_n && !brk_o && !brk_set_i) |=> !dbg_irq_o);

  a_r8_pend_holds: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_rst_n && acc_pend_o && !probe_ivalid_i) |=> acc_pend_o);

  a_r9_release: assert property (@(posedge clk) disable iff (!por_n)
    (acc_pend_o && probe_ivalid_i) |=> !acc_pend_o);

  a_r10_stall_needs_pen: assert property (@(posedge clk) disable iff (!por_n)
    stall_o |-> pen_o);

  a_r10_no_pen_no_pend: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_rst_n && !pen_o && !acc_pend_o) |=> !acc_pend_o);
endmodule

bind dbgboot_ctrl dbgboot_chk u_chk (
  .clk            (clk),
  .por_n          (por_n),
  .cpu_rst_n      (cpu_rst_n),
  .tap_dbgboot_i  (tap_dbgboot_i),
  .tap_normboot_i (tap_normboot_i),
  .brk_set_i      (brk_set_i),
  .pfetch_i       (pfetch_i),
  .probe_ivalid_i (probe_ivalid_i),
  .boot_ind_o     (boot_ind_o),
  .brk_o          (brk_o),
  .trap_o         (trap_o),
  .pen_o          (pen_o),
  .dbg_irq_o      (dbg_irq_o),
  .stall_o        (stall_o),
  .acc_pend_o     (acc_pend_o)
);

// File: tb/dbgboot_ctrl_bench.sv
`timescale 1ns/1ps
module dbgboot_ctrl_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        cpu_rst_n = 1'b0;
  logic        tap_dbgboot_i = 1'b0;
  logic        tap_normboot_i = 1'b0;
  logic        brk_set_i = 1'b0;
  logic        brk_ack_i = 1'b0;
  logic        pfetch_i = 1'b0;
  logic        probe_ivalid_i = 1'b0;
  logic        boot_ind_o, brk_o, trap_o, pen_o, dbg_irq_o, stall_o, acc_pend_o;
  logic [31:0] fetch_vec_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbgboot_ctrl u_dbgboot_ctrl (
    .clk            (clk),
    .por_n          (por_n),
    .cpu_rst_n      (cpu_rst_n),
    .tap_dbgboot_i  (tap_dbgboot_i),
    .tap_normboot_i (tap_normboot_i),
    .brk_set_i      (brk_set_i),
    .brk_ack_i      (brk_ack_i),
    .pfetch_i       (pfetch_i),
    .probe_ivalid_i (probe_ivalid_i),
    .boot_ind_o     (boot_ind_o),
    .brk_o          (brk_o),
    .trap_o         (trap_o),
    .pen_o          (pen_o),
    .dbg_irq_o      (dbg_irq_o),
    .fetch_vec_o    (fetch_vec_o),
    .stall_o        (stall_o),
    .acc_pend_o     (acc_pend_o)
  );

  function automatic logic [31:0] exp_vec(input int trap);
    // debug vector = probe segment base plus 0x200; normal = boot ROM base
    return (trap != 0) ? (32'hFF20_0000 + 32'd512) : (32'hBFC0_0000);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog act=hang exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) nx();
    #2;
    chk("R1 boot", boot_ind_o, 0);
    chk("R1 brk", brk_o, 0);
    chk("R1 trap", trap_o, 0);
    chk("R1 pen", pen_o, 0);
    chk("R1 irq", dbg_irq_o, 0);
    chk("R1 stall", stall_o, 0);
    chk("R1 pend", acc_pend_o, 0);
    chk("R1 vec", fetch_vec_o, exp_vec(0));
    nx();
    por_n = 1'b1;

    for (int b = 0; b < 2; b++) begin
      for (int ad = 1; ad <= 3; ad++) begin
        for (int pd = 0; pd <= 2; pd++) begin
          nx();
          cpu_rst_n = 1'b0;
          if (b != 0) tap_dbgboot_i = 1'b1;
          else        tap_normboot_i = 1'b1;
          nx();
          tap_dbgboot_i = 1'b0;
          tap_normboot_i = 1'b0;
          #2;
          if (b != 0) chk("R2 set", boot_ind_o, 1);
          else        chk("R3 clear", boot_ind_o, 0);
          nx();
          #2;
          chk("R2 survives reset", boot_ind_o, b);
          chk("R4 brk", brk_o, b);
          chk("R4 trap", trap_o, b);
          chk("R4 pen", pen_o, b);
          chk("R5 vec", fetch_vec_o, exp_vec(b));
          nx();
          cpu_rst_n = 1'b1;
          #2;
          chk("R6 irq first cycle", dbg_irq_o, b);
          chk("R8 stall first cycle", stall_o, b);
          nx();
          #2;
          chk("R6 irq one cycle", dbg_irq_o, 0);
          chk("R8 pend", acc_pend_o, b);
          for (int k = 0; k < pd; k++) begin
            nx();
            #2;
            chk("R8 stall held", stall_o, b);
            chk("R8 pend held", acc_pend_o, b);
          end
          nx();
          probe_ivalid_i = 1'b1;
          #2;
          chk("R9 stall released", stall_o, 0);
          nx();
          probe_ivalid_i = 1'b0;
          #2;
          chk("R9 pend cleared", acc_pend_o, 0);
          chk("R9 stall low", stall_o, 0);
          for (int k = 0; k < ad; k++) nx();
          brk_ack_i = 1'b1;
          nx();
          brk_ack_i = 1'b0;
          #2;
          chk("R7 ack clears brk", brk_o, 0);
          chk("R7 irq low", dbg_irq_o, 0);
          for (int k = 0; k < 2; k++) begin
            nx();
            #2;
            chk("R7 no retrigger", dbg_irq_o, 0);
          end
        end
      end
    end

    // R3: clear wins over set
    nx();
    tap_dbgboot_i = 1'b1;
    tap_normboot_i = 1'b1;
    nx();
    tap_dbgboot_i = 1'b0;
    tap_normboot_i = 1'b0;
    #2;
    chk("R3 clear priority", boot_ind_o, 0);

    // R7: set/ack interplay after a debug boot
    cpu_rst_n = 1'b0;
    tap_dbgboot_i = 1'b1;
    nx();
    tap_dbgboot_i = 1'b0;
    nx();
    nx();
    cpu_rst_n = 1'b1;
    #2;
    chk("R6 irq", dbg_irq_o, 1);
    nx();
    brk_set_i = 1'b1;
    brk_ack_i = 1'b1;
    #2;
    chk("R7 no repeat", dbg_irq_o, 0);
    nx();
    brk_set_i = 1'b0;
    brk_ack_i = 1'b0;
    #2;
    chk("R7 set wins", brk_o, 1);
    chk("R7 no irq while set", dbg_irq_o, 0);
    brk_ack_i = 1'b1;
    nx();
    brk_ack_i = 1'b0;
    #2;
    chk("R7 cleared", brk_o, 0);
    nx();
    brk_set_i = 1'b1;
    nx();
    brk_set_i = 1'b0;
    #2;
    chk("R7 set again", brk_o, 1);
    chk("R7 irq again", dbg_irq_o, 1);

    // R9/R10: answer the boot fetch, then a further probe fetch
    probe_ivalid_i = 1'b1;
    nx();
    probe_ivalid_i = 1'b0;
    #2;
    chk("R9 pend clear", acc_pend_o, 0);
    nx();
    pfetch_i = 1'b1;
    #2;
    chk("R10 stall on fetch", stall_o, 1);
    nx();
    pfetch_i = 1'b0;
    #2;
    chk("R10 pend on fetch", acc_pend_o, 1);
    probe_ivalid_i = 1'b1;
    nx();
    probe_ivalid_i = 1'b0;
    #2;
    chk("R9 pend clear again", acc_pend_o, 0);
    probe_ivalid_i = 1'b1;
    nx();
    probe_ivalid_i = 1'b0;
    #2;
    chk("R9 valid ignored", acc_pend_o, 0);
    chk("R9 stall idle", stall_o, 0);

    // R1: asynchronous power-on clear mid-run
    por_n = 1'b0;
    #2;
    chk("R1 por boot", boot_ind_o, 0);
    chk("R1 por brk", brk_o, 0);
    chk("R1 por trap", trap_o, 0);
    chk("R1 por pen", pen_o, 0);
    chk("R1 por vec", fetch_vec_o, exp_vec(0));
    nx();
    por_n = 1'b1;

    // R10: no probe service -> fetch ignored
    cpu_rst_n = 1'b0;
    nx();
    nx();
    cpu_rst_n = 1'b1;
    nx();
    pfetch_i = 1'b1;
    #2;
    chk("R10 no stall", stall_o, 0);
    nx();
    pfetch_i = 1'b0;
    #2;
    chk("R10 no pend", acc_pend_o, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule